// File: doc/BRIEF.md
# Clock-Period Counter with Wrap Interrupt

This block is a free-running timer that advances by one on every clock edge. Software reads the low-order count through a read port. Each time the count rolls over from all ones to zero, the block raises a pending-wrap flag. That flag drives an interrupt request, and the request carries a fixed handler address.

Software keeps the full-width time by counting wraps in its handler. A read returns the pending-wrap flag as an extra bit above the count. This lets software see a rollover that has happened but has not yet been serviced. Software can then correct a timestamp taken just after the wrap.

The handler clears the flag when its execution interval ends. A rollover that arrives on the same edge as the clear is not lost.

Top module: `cpc_timer_top`

## Requirements
- R1: A synchronous active-high reset sets the count to zero and the pending-wrap flag to zero; both stay zero while reset is held.
- R2: Outside reset, the count increases by exactly one on every clock edge, modulo 2^CNT_W, with no input needed.
- R3: On the edge where the count moves from all ones to zero, the pending-wrap flag becomes 1.
- R4: The read value is CNT_W+1 bits wide: bits CNT_W-1..0 hold the count and bit CNT_W holds the pending-wrap flag.
- R5: The interrupt request output equals the pending-wrap flag. The vector output is constantly the handler address parameter, which defaults to 20 octal.
- R6: A clear pulse drives the flag to 0 on the next edge when no rollover happens on that edge. The clear leaves the count unaffected.
- R7: When a rollover and a clear fall on the same edge, the flag is 1 after that edge.
- R8: A clear while the flag is already 0 has no effect: the flag stays 0 and the count keeps stepping by one.
- R9: Once set, the flag stays 1 through further counting and further rollovers until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_clr | input | 1 | End-of-handler clear of the pending-wrap flag |
| rd_data | output | CNT_W+1 | Read value: flag in the top bit, count below it |
| irq_req | output | 1 | Interrupt request, high while a wrap is pending |
| irq_vector | output | ADDR_W | Handler address that accompanies the request |

## Verification
The bench builds the block with CNT_W = 5, so a rollover comes every 32 cycles instead of every 131072. This puts several rollovers within a short run. It also makes the clear-on-rollover collision and the sticky flag across a second rollover reachable. ADDR_W and the handler address keep their defaults, so the vector checks see the production value of 20 octal.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    // Action taken on the pending-wrap flag at one clock edge.
    typedef enum logic [1:0] {
        FLG_KEEP  = 2'd0,
        FLG_RAISE = 2'd1,
        FLG_DROP  = 2'd2
    } flag_op_e;

    // Control inputs that steer the flag in one cycle.
    typedef struct packed {
        logic wrap;
        logic clr;
    } flag_ctl_t;

    // A rollover wins over a clear, so a wrap is never lost.
    function automatic flag_op_e pick_flag_op(input flag_ctl_t ctl);
        if (ctl.wrap) begin
            return FLG_RAISE;
        end
        if (ctl.clr) begin
            return FLG_DROP;
        end
        return FLG_KEEP;
    endfunction

endpackage

// File: rtl/cpc_tick_counter.sv
module cpc_tick_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [SUM_W-1:0] sum;

    // The carry out of the top bit marks the rollover edge.
    assign sum     = {1'b0, count_q} + SUM_W'(1);
    assign wrap_o  = sum[CNT_W];
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= sum[CNT_W-1:0];
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> count_o == '0); // R3

endmodule

// File: rtl/cpc_wrap_flag.sv
module cpc_wrap_flag
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_ctl_t ctl;
    flag_op_e  op;
    logic      flag_q;

    always_comb begin
        ctl.wrap = wrap_i;
        ctl.clr  = clr_i;
        op       = pick_flag_op(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            case (op)
                FLG_RAISE: flag_q <= 1'b1;
                FLG_DROP:  flag_q <= 1'b0;
                default:   flag_q <= flag_q;
            endcase
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> flag_o); // R7

    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !wrap_i) |=> !flag_o); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R9

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !wrap_i) |=> !flag_o); // R8

endmodule

// File: rtl/cpc_read_port.sv
module cpc_read_port #(
    parameter int CNT_W = 17
) (
    input  logic           flag_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W:0] rd_data_o
);
    // The pending flag sits above the count so software can correct a racing read.
    assign rd_data_o = {flag_i, count_i};

endmodule

// File: rtl/cpc_timer_top.sv
module cpc_timer_top #(
    parameter int              CNT_W        = 17,
    parameter int              ADDR_W       = 18,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = ADDR_W'('o20)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_clr,
    output logic [CNT_W:0]    rd_data,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vector
);
    localparam int RD_W = CNT_W + 1;

    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             flag;
    logic [RD_W-1:0]  rd_word;

    cpc_tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .count_o (count),
        .wrap_o  (wrap)
    );

    cpc_wrap_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .wrap_i (wrap),
        .clr_i  (irq_clr),
        .flag_o (flag)
    );

    cpc_read_port #(.CNT_W(CNT_W)) u_read (
        .flag_i    (flag),
        .count_i   (count),
        .rd_data_o (rd_word)
    );

    assign rd_data    = rd_word;
    assign irq_req    = flag;
    assign irq_vector = HANDLER_ADDR;

    AST_RD_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        rd_data[CNT_W] == irq_req); // R4

endmodule

// File: tb/tb_cpc_timer_top.sv
module tb_cpc_timer_top;
    localparam int CNT_W  = 5;
    localparam int ADDR_W = 18;
    localparam logic [CNT_W-1:0] MAXC = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              irq_clr = 1'b0;
    logic [CNT_W:0]    rd_data;
    logic              irq_req;
    logic [ADDR_W-1:0] irq_vector;

    int checks   = 0;
    int failures = 0;

    cpc_timer_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .irq_clr    (irq_clr),
        .rd_data    (rd_data),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_count(input logic [CNT_W-1:0] v);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rd_data[CNT_W-1:0] == v) return;
        end
        chk("wait_count reached", 32'(rd_data[CNT_W-1:0]), 32'(v));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset read value", 32'(rd_data), 32'd0);
        chk("R1 reset irq", 32'(irq_req), 32'd0);
        chk("R5 vector", 32'(irq_vector), 32'o20);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 first count", 32'(rd_data), 32'd1);
    endtask

    task automatic t_count;
        logic [CNT_W-1:0] prev;
        prev = rd_data[CNT_W-1:0];
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 step", 32'(rd_data[CNT_W-1:0]), 32'(CNT_W'(prev + 1'b1)));
            chk("R4 flag bit low", 32'(rd_data[CNT_W]), 32'd0);
            prev = rd_data[CNT_W-1:0];
        end
    endtask

    task automatic t_wrap;
        wait_count(MAXC);
        chk("R3 no flag before wrap", 32'(irq_req), 32'd0);
        @(negedge clk);
        chk("R2 wrap to zero", 32'(rd_data[CNT_W-1:0]), 32'd0);
        chk("R3 flag set", 32'(irq_req), 32'd1);
        chk("R4 read layout", 32'(rd_data), 32'h20);
        chk("R5 irq follows flag", 32'(irq_req), 32'(rd_data[CNT_W]));
    endtask

    task automatic t_sticky;
        wait_count(5'd12);
        chk("R9 flag held mid count", 32'(irq_req), 32'd1);
        wait_count(MAXC);
        @(negedge clk);
        chk("R9 flag held after second wrap", 32'(irq_req), 32'd1);
        chk("R9 count zero", 32'(rd_data[CNT_W-1:0]), 32'd0);
    endtask

    task automatic t_clear;
        wait_count(5'd10);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R6 flag cleared", 32'(irq_req), 32'd0);
        chk("R6 count unaffected", 32'(rd_data[CNT_W-1:0]), 32'd11);
    endtask

    task automatic t_clr_idle;
        wait_count(5'd15);
        irq_clr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 flag stays clear", 32'(irq_req), 32'd0);
            chk("R8 count steps", 32'(rd_data[CNT_W-1:0]), 32'(16 + i));
        end
        irq_clr = 1'b0;
    endtask

    task automatic t_collide;
        wait_count(MAXC);
        chk("R7 flag clear before", 32'(irq_req), 32'd0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R7 wrap beats clear", 32'(irq_req), 32'd1);
        chk("R7 count zero", 32'(rd_data[CNT_W-1:0]), 32'd0);
    endtask

    task automatic t_reset_mid;
        wait_count(5'd7);
        chk("R1 flag set before reset", 32'(irq_req), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset read", 32'(rd_data), 32'd0);
        @(negedge clk);
        chk("R1 held reset", 32'(rd_data), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 restart count", 32'(rd_data), 32'd1);
    endtask

    initial begin
        #(5 * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_sticky();
        t_clear();
        t_clr_idle();
        t_collide();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule